// File: doc/BRIEF.md
# Configurable PLA Logic Slice

This block is one logic slice of a small programmable fabric. Each cycle it takes a bus of interconnect signals and turns each one into a true and a complement literal. A programmable AND plane forms product terms from those literals, and a programmable OR plane sums any chosen set of those terms into each cell output. Some product terms have special roles. Each cell owns one fast term. A group of control terms can be sent out as per-cell control signals for clock, reset, preset or output enable. A group of NAND foldback terms can be fed back into the AND plane so that wider functions can be built. When a special term is not used for its role, it rejoins the shared pool as an ordinary term.

The whole personality is held in one configuration register. Software loads it one bit per cycle, most significant bit first, while `cfg_en` is high. The slice then goes live on a `cfg_done` strobe. The loader has no back-pressure: the slice accepts a configuration bit on every cycle in which `cfg_en` is high. The logic inputs are also taken on every cycle with no handshake. The outputs are registered, so each sample appears one clock edge after the cycle in which it was presented.

The default geometry is 36 inputs, 48 product terms and 16 cells. Terms 0 to 15 are the fast terms of cells 0 to 15. Terms 16 to 23 are the control terms. Terms 24 to 31 are the foldback terms. Terms 32 to 47 are pure pool terms.

Top module: `pla_slice`

## Requirements
- R1: While `rst_n` is low, the configuration register is cleared, the slice is not live, and `cell_out` and `ctl_out` are all zero.
- R2: On each cycle with `cfg_en` high, the configuration register shifts left by one and takes `cfg_bit` into bit 0, so the first bit shifted ends up at the top index. The outputs stay zero until a cycle with `cfg_done` high and `cfg_en` low. From that cycle on, each input sample shows on the outputs one clock edge later.
- R3: AND-plane bit `t*80 + 2*i` enables the true literal of input i in term t. Bit `t*80 + 2*i + 1` enables its complement. Bit `t*80 + 72 + k` enables foldback literal k. A term is the AND of the literals it has enabled.
- R4: A product term with no literal enabled evaluates to 1. A cell with no OR-plane bit set drives 0.
- R5: A term that enables both the true and the complement literal of the same input is always 0.
- R6: OR-plane bit `3840 + c*48 + t` adds term t into cell c. A cell output is the OR of the available terms it selects.
- R7: Any cell may select its own fast term (term c) together with any of the other 47 terms. One term may feed several cells at once.
- R8: When control-use bit `4608 + k` is set, `ctl_out[k]` carries term 16+k and that term is removed from the OR plane. When the bit is clear, `ctl_out[k]` is 0 and the term is an ordinary OR-plane term.
- R9: When foldback bit 4616 is set, foldback literal k equals the NAND of term 24+k, and terms 24 to 31 are removed from the OR plane. When the bit is clear, every foldback literal reads 1 and terms 24 to 31 act as ordinary terms. Foldback-literal enables on terms 24 to 31 themselves have no effect.
- R10: Raising `cfg_en` takes the slice out of live operation, and the outputs read zero from the next edge. A `cfg_done` given while `cfg_en` is high is ignored, and a fresh `cfg_done` is needed afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration register |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| cfg_done | input | 1 | Strobe that makes the loaded configuration live |
| in_sig | input | 36 | Interconnect inputs to the literal generator |
| cell_out | output | 16 | Registered per-cell sum-of-products outputs |
| ctl_out | output | 8 | Registered exported control terms |

## Verification
The bench targets these corner cases:

- A term with no literals enabled. A design that returned 0 for it would lose the constant-one cell.
- A term that enables both literals of one input. A design that let it pass would show input-dependent activity on that cell.
- A cell with an empty OR row. This would read 1 in a design that inverted the empty-sum rule.
- Control and foldback terms in both of their roles. A design that failed to pull a claimed term out of the pool would leak it into the cells. One that forgot the NAND inversion, or gave a disabled foldback literal any value but 1, would corrupt the wider functions built on it.
- A done strobe given during shifting, and samples presented before any done. A design that went live early would expose partial configurations.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    ROLE_FAST = 2'd0,
    ROLE_CTL  = 2'd1,
    ROLE_FOLD = 2'd2,
    ROLE_POOL = 2'd3
  } term_role_e;

  // Fixed term layout: fast terms first, then control, then foldback, then pool.
  function automatic term_role_e role_of(input int t, input int n_cell,
                                         input int n_ctl, input int n_fb);
    if (t < n_cell)                    return ROLE_FAST;
    else if (t < n_cell + n_ctl)       return ROLE_CTL;
    else if (t < n_cell + n_ctl + n_fb) return ROLE_FOLD;
    else                               return ROLE_POOL;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int CFG_W = 4617
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  input  logic             cfg_done,
  output logic [CFG_W-1:0] cfg_q,
  output logic             live_q,
  output logic             live_nx
);

  // Loading always wins over a done strobe in the same cycle.
  always_comb begin
    if (cfg_en)        live_nx = 1'b0;
    else if (cfg_done) live_nx = 1'b1;
    else               live_nx = live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      live_q <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= {cfg_q[CFG_W-2:0], cfg_bit};
      live_q <= live_nx;
    end
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 36,
  parameter int N_PT   = 48,
  parameter int N_CELL = 16,
  parameter int N_CTL  = 8,
  parameter int N_FB   = 8,
  localparam int LIT_W = 2 * N_IN + N_FB
) (
  input  logic [N_IN-1:0]       in_sig,
  input  logic [N_PT*LIT_W-1:0] and_cfg,
  input  logic                  fb_en,
  output logic [N_PT-1:0]       pt
);

  localparam int FB_BASE = N_CELL + N_CTL;

  logic [2*N_IN-1:0] lit_in;
  logic [N_FB-1:0]   fb_pt;
  logic [N_FB-1:0]   fb_lit;

  // Literal pairs: even index true, odd index complement.
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_in[2*i]   = in_sig[i];
    assign lit_in[2*i+1] = ~in_sig[i];
  end

  // Foldback terms see only input literals; their own foldback slots read 1.
  for (genvar k = 0; k < N_FB; k++) begin : g_fold
    logic [LIT_W-1:0] row;
    assign row      = and_cfg[(FB_BASE+k)*LIT_W +: LIT_W];
    assign fb_pt[k] = &(~row | {{N_FB{1'b1}}, lit_in});
    assign fb_lit[k] = fb_en ? ~fb_pt[k] : 1'b1;
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    if (role_of(t, N_CELL, N_CTL, N_FB) == ROLE_FOLD) begin : g_fb
      assign pt[t] = fb_pt[t - FB_BASE];
    end else begin : g_std
      logic [LIT_W-1:0] row;
      assign row   = and_cfg[t*LIT_W +: LIT_W];
      assign pt[t] = &(~row | {fb_lit, lit_in});
    end
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int N_PT   = 48,
  parameter int N_CELL = 16,
  parameter int N_CTL  = 8,
  parameter int N_FB   = 8
) (
  input  logic [N_PT-1:0]        pt,
  input  logic [N_CELL*N_PT-1:0] or_cfg,
  input  logic [N_CTL-1:0]       ctl_use,
  input  logic                   fb_en,
  output logic [N_CELL-1:0]      sum,
  output logic [N_CTL-1:0]       ctl
);

  localparam int CTL_BASE = N_CELL;

  logic [N_PT-1:0] avail;

  for (genvar t = 0; t < N_PT; t++) begin : g_avail
    if (role_of(t, N_CELL, N_CTL, N_FB) == ROLE_CTL) begin : g_c
      assign avail[t] = pt[t] & ~ctl_use[t - CTL_BASE];
    end else if (role_of(t, N_CELL, N_CTL, N_FB) == ROLE_FOLD) begin : g_f
      assign avail[t] = pt[t] & ~fb_en;
    end else begin : g_p
      assign avail[t] = pt[t];
    end
  end

  for (genvar k = 0; k < N_CTL; k++) begin : g_ctl
    assign ctl[k] = pt[CTL_BASE + k] & ctl_use[k];
  end

  for (genvar c = 0; c < N_CELL; c++) begin : g_sum
    assign sum[c] = |(or_cfg[c*N_PT +: N_PT] & avail);
  end

endmodule

// File: rtl/pla_slice.sv
module pla_slice #(
  parameter int N_IN   = 36,
  parameter int N_PT   = 48,
  parameter int N_CELL = 16,
  parameter int N_CTL  = 8,
  parameter int N_FB   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_bit,
  input  logic              cfg_done,
  input  logic [N_IN-1:0]   in_sig,
  output logic [N_CELL-1:0] cell_out,
  output logic [N_CTL-1:0]  ctl_out
);

  localparam int LIT_W    = 2 * N_IN + N_FB;
  localparam int AND_W    = N_PT * LIT_W;
  localparam int OR_W     = N_CELL * N_PT;
  localparam int CTLU_LSB = AND_W + OR_W;
  localparam int FBEN_BIT = CTLU_LSB + N_CTL;
  localparam int CFG_W    = FBEN_BIT + 1;

  logic [CFG_W-1:0]  cfg_q;
  logic              cfg_live;
  logic              live_nx;
  logic [N_PT-1:0]   pt;
  logic [N_CTL-1:0]  ctl_use;
  logic              fb_en;
  logic [N_CELL-1:0] cell_sum;
  logic [N_CTL-1:0]  ctl_w;

  pla_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .cfg_q(cfg_q), .live_q(cfg_live), .live_nx(live_nx)
  );

  assign ctl_use = cfg_q[CTLU_LSB +: N_CTL];
  assign fb_en   = cfg_q[FBEN_BIT];

  pla_and_plane #(
    .N_IN(N_IN), .N_PT(N_PT), .N_CELL(N_CELL), .N_CTL(N_CTL), .N_FB(N_FB)
  ) u_and (
    .in_sig(in_sig), .and_cfg(cfg_q[AND_W-1:0]), .fb_en(fb_en), .pt(pt)
  );

  pla_or_plane #(
    .N_PT(N_PT), .N_CELL(N_CELL), .N_CTL(N_CTL), .N_FB(N_FB)
  ) u_or (
    .pt(pt), .or_cfg(cfg_q[AND_W +: OR_W]), .ctl_use(ctl_use), .fb_en(fb_en),
    .sum(cell_sum), .ctl(ctl_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_out <= '0;
      ctl_out  <= '0;
    end else begin
      cell_out <= live_nx ? cell_sum : '0;
      ctl_out  <= live_nx ? ctl_w : '0;
    end
  end

endmodule

// File: rtl/pla_slice_chk.sv
module pla_slice_chk #(
  parameter int N_CELL = 16,
  parameter int N_CTL  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              cfg_done,
  input logic              live,
  input logic [N_CELL-1:0] sum_w,
  input logic [N_CTL-1:0]  ctl_use,
  input logic [N_CELL-1:0] cell_out,
  input logic [N_CTL-1:0]  ctl_out
);

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (cell_out == '0 && ctl_out == '0);
    end
  end

  assert_live_needs_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && !cfg_done) |=> !live);

  assert_load_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cell_out == '0 && ctl_out == '0 && !live));

  assert_out_from_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cell_out & ~$past(sum_w)) == '0));

  assert_ctl_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ctl_out & ~$past(ctl_use)) == '0));

endmodule

bind pla_slice pla_slice_chk #(.N_CELL(N_CELL), .N_CTL(N_CTL)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_done(cfg_done),
  .live(cfg_live), .sum_w(cell_sum), .ctl_use(ctl_use),
  .cell_out(cell_out), .ctl_out(ctl_out)
);

// File: tb/tb_pla_slice.sv
module tb_pla_slice;

  localparam int NI = 36, NP = 48, NC = 16, NK = 8, NF = 8;
  localparam int LW = 2 * NI + NF;
  localparam int OR_LSB = NP * LW;
  localparam int CU_LSB = OR_LSB + NC * NP;
  localparam int FB_BIT = CU_LSB + NK;
  localparam int CW = FB_BIT + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_bit = 1'b0, cfg_done = 1'b0;
  logic [NI-1:0] in_sig = '0;
  logic [NC-1:0] cell_out;
  logic [NK-1:0] ctl_out;

  logic [CW-1:0] img;
  logic [63:0]   rs = 64'h9E37_79B9_7F4A_7C15;
  bit            live_exp = 1'b0;
  int            checks = 0, fails = 0;

  logic [NK+NC-1:0] exp_q[$];
  string            tag_q[$];

  always #10 clk = ~clk;

  pla_slice dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .in_sig(in_sig), .cell_out(cell_out), .ctl_out(ctl_out)
  );

  function automatic logic [NK+NC-1:0] model(logic [NI-1:0] v, bit lv);
    logic [2*NI-1:0] li;
    logic [NF-1:0]   fbl;
    logic [NP-1:0]   pt, av;
    logic [NC-1:0]   s;
    logic [NK-1:0]   c;
    logic            p, fben, lval;
    if (!lv) return '0;
    fben = img[FB_BIT];
    for (int i = 0; i < NI; i++) begin
      li[2*i] = v[i];
      li[2*i+1] = ~v[i];
    end
    for (int k = 0; k < NF; k++) begin
      p = 1'b1;
      for (int l = 0; l < 2*NI; l++)
        if (img[(24+k)*LW + l] && !li[l]) p = 1'b0;
      pt[24+k] = p;
      fbl[k] = fben ? ~p : 1'b1;
    end
    for (int t = 0; t < NP; t++) begin
      if (t < 24 || t > 31) begin
        p = 1'b1;
        for (int l = 0; l < LW; l++) begin
          lval = (l < 2*NI) ? li[l] : fbl[l - 2*NI];
          if (img[t*LW + l] && !lval) p = 1'b0;
        end
        pt[t] = p;
      end
    end
    for (int t = 0; t < NP; t++) begin
      if (t >= 16 && t < 24)      av[t] = pt[t] & ~img[CU_LSB + t - 16];
      else if (t >= 24 && t < 32) av[t] = pt[t] & ~fben;
      else                        av[t] = pt[t];
    end
    for (int k = 0; k < NK; k++) c[k] = pt[16+k] & img[CU_LSB + k];
    for (int q = 0; q < NC; q++) s[q] = |(img[OR_LSB + q*NP +: NP] & av);
    return {c, s};
  endfunction

  task automatic and_lit(int t, int l); img[t*LW + l] = 1'b1; endtask
  task automatic or_sel(int c, int t);  img[OR_LSB + c*NP + t] = 1'b1; endtask

  task automatic nextrand(output logic [NI-1:0] v);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    v = rs[NI-1:0];
  endtask

  task automatic step(logic [NI-1:0] v, bit dn, string tag);
    @(negedge clk);
    in_sig = v; cfg_en = 1'b0; cfg_done = dn; cfg_bit = 1'b0;
    if (dn) live_exp = 1'b1;
    exp_q.push_back(model(v, live_exp));
    tag_q.push_back(tag);
  endtask

  task automatic load(bit done_during);
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_bit = img[i];
      cfg_done = done_during && (i == 0);
      live_exp = 1'b0;
      if (i == CW - 1) begin
        exp_q.push_back('0);
        tag_q.push_back("R10 outputs drop when loading starts");
      end
    end
  endtask

  // Scoreboard monitor
  initial begin
    logic [NK+NC-1:0] e;
    string tg;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if ({ctl_out, cell_out} !== e) begin
          fails++;
          $display("FAIL %s: cells=%h exp=%h ctl=%h exp=%h",
                   tg, cell_out, e[NC-1:0], ctl_out, e[NK+NC-1:NC]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NI-1:0] v;
    repeat (3) @(negedge clk);
    checks++;
    if (cell_out !== '0 || ctl_out !== '0) begin
      fails++;
      $display("FAIL R1 reset: cells=%h ctl=%h exp=0", cell_out, ctl_out);
    end
    rst_n = 1'b1;

    // Config A: R3 R4 R5 R6 R7 plus R8/R9 in their plain roles
    img = '0;
    and_lit(0, 0); and_lit(0, 3); or_sel(0, 0);        // in0 & ~in1
    or_sel(1, 1);                                      // R4 empty term -> 1
    and_lit(3, 10); and_lit(3, 11); or_sel(3, 3);      // R5 in5 & ~in5
    and_lit(32, 4); and_lit(32, 6); and_lit(47, 70);
    or_sel(4, 32); or_sel(4, 47); or_sel(5, 32);       // R7 shared pool
    and_lit(16, 14); or_sel(6, 16);                    // R8 unused ctl term
    and_lit(17, 16); and_lit(17, 18); or_sel(7, 17);
    img[CU_LSB + 1] = 1'b1;                            // R8 claimed ctl term
    and_lit(24, 20); and_lit(24, 73); or_sel(8, 24);   // R9 fold disabled
    and_lit(33, 72); and_lit(33, 22); or_sel(9, 33);
    and_lit(10, 25); or_sel(10, 10);                   // R7 fast term
    for (int t = 0; t < NP; t++) or_sel(11, t);
    load(1'b0);
    for (int n = 0; n < 4; n++) begin
      nextrand(v);
      step(v, 1'b0, "R2 outputs held before done");
    end
    step(36'h0_0000_0001, 1'b1, "R2 first live sample");
    step(36'h0_0000_0000, 1'b0, "R4 R5 R6 all-zero inputs");
    step(36'hF_FFFF_FFFF, 1'b0, "R4 R5 R6 all-one inputs");
    step(36'h8_0000_000C, 1'b0, "R7 shared pool terms");
    step(36'h0_0000_0300, 1'b0, "R8 claimed ctl term");
    for (int n = 0; n < 40; n++) begin
      nextrand(v);
      step(v, 1'b0, "R3 R6 R8 R9 cfgA random");
    end

    // Config B: foldback on, control use moved to term 16
    img[FB_BIT] = 1'b1;
    img[CU_LSB + 1] = 1'b0;
    img[CU_LSB + 0] = 1'b1;
    load(1'b1);
    for (int n = 0; n < 3; n++) begin
      nextrand(v);
      step(v, 1'b0, "R10 done during load ignored");
    end
    step(36'h0_0000_0800, 1'b1, "R9 foldback NAND literal");
    step(36'h0_0000_0C00, 1'b0, "R9 foldback NAND literal");
    step(36'h0_0000_0080, 1'b0, "R8 ctl export term 16");
    for (int n = 0; n < 40; n++) begin
      nextrand(v);
      step(v, 1'b0, "R8 R9 cfgB random");
    end

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule